// File: doc/BRIEF.md
# Serial Channel FIFO Status Controller

This block buffers the byte stream of one serial channel in both directions. A transmit FIFO is loaded from a small register interface and drained by the serial line logic. A receive FIFO is filled by the serial line logic and drained through the same register interface. Both FIFOs hold byte entries, and their depth is a parameter (default 16).

Three word registers are selected by a two-bit select code. The level register holds two programmable thresholds. The data register pushes into the transmit FIFO on a write and pops the receive FIFO on a read. The control/status register reports four active-low level flags for each FIFO, two sticky overflow bits that are cleared by writing one, and a receive underflow bit. Register reads are registered: the selected word appears on `reg_rdata` one clock after `reg_rd`.

Each FIFO has its own almost-full and almost-empty conditions. When either condition becomes true, the block raises a one-cycle interrupt pulse, which a separate aggregation stage can collect.

Top module: `serial_chan_buf`

## Requirements
- R1: After reset both FIFOs are empty, both thresholds read as zero, every sticky bit is clear, `tx_valid` is low, and the status word (select 2) reads 0x0000_CC00.
- R2: A write to select 1 pushes `reg_wdata[7:0]` into the transmit FIFO and ignores bits 31:8. `tx_valid` is high while the FIFO holds data, `tx_data` shows the oldest byte, and `tx_pop` removes that byte. Bytes leave in the order they were written.
- R3: A read of select 1 pops the receive FIFO. The popped byte appears in `reg_rdata[7:0]` with bits 31:8 zero, and bytes come out in the order `rx_push` delivered them.
- R4: Status bit 15 (receive) and bit 11 (transmit) are 0 exactly when that FIFO holds DEPTH bytes. Bit 12 (receive) and bit 8 (transmit) are 0 exactly when it holds none.
- R5: Status bit 14 (receive) and bit 10 (transmit) are 0 exactly when the FIFO count plus the almost-full value is at least DEPTH.
- R6: Status bit 13 (receive) and bit 9 (transmit) are 0 exactly when the FIFO count is less than or equal to the almost-empty value.
- R7: Select 0 is the level register. Bits 31:16 hold the almost-full value and bits 15:0 hold the almost-empty value. A write stores both fields and a read returns them.
- R8: An `rx_push` while the receive FIFO is full and no pop happens in the same cycle drops the byte and leaves the FIFO contents unchanged. It also sets status bit 16, which stays set until a status write with bit 16 at 1. Writing 0 there has no effect. A push that coincides with a pop of a full FIFO is accepted.
- R9: A data write while the transmit FIFO is full and `tx_pop` is low drops the byte and leaves the contents unchanged. It also sets status bit 17, which is cleared only by a status write with bit 17 at 1.
- R10: A data read while the receive FIFO is empty returns 0 and moves nothing. It sets status bit 18, which then holds until the next data read, and that read sets it again only if it also finds the FIFO empty.
- R11: Each of the four interrupt outputs pulses high for exactly one cycle when its condition (R5 or R6, per FIFO) goes from false to true. It stays low in the cycles that follow reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 levels, 1 data, 2 status, 3 unused |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| tx_valid | output | 1 | Transmit FIFO holds data |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Line side takes the oldest transmit byte |
| rx_push | input | 1 | Line side delivers a received byte |
| rx_data | input | 8 | Received byte |
| irq_rx_afull | output | 1 | Pulse: receive almost-full became true |
| irq_rx_aempty | output | 1 | Pulse: receive almost-empty became true |
| irq_tx_afull | output | 1 | Pulse: transmit almost-full became true |
| irq_tx_aempty | output | 1 | Pulse: transmit almost-empty became true |

## Verification
The FIFO counts change on the edge that sees a push or pop. From that cycle on, the level flags and the interrupt pulses reflect the new count, and each pulse is gone one edge later. Register reads return their word on `reg_rdata` after the edge that samples `reg_rd`, carrying the state from before that edge. The bench drives every stimulus just after a falling edge and samples at the next falling edge. It therefore reads a pulse in the cycle it is due and reads a status word one operation after the event it reports. With DEPTH 4, it sweeps every pair of thresholds from 0 to 5 against every fill level of both FIFOs, and computes each flag and each pulse arithmetically from the count.

// File: rtl/scb_pkg.sv
// Package: shared widths, register select codes, status bit positions and
// the active-low flag bundle used by the serial channel buffer.
package scb_pkg;
    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int THR_W  = 16;

    // Register select codes seen on reg_sel.
    typedef enum logic [1:0] {
        SEL_LEVELS = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_CSR    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Status word bit positions.
    localparam int CSR_RX_OV_BIT = 16;
    localparam int CSR_TX_OV_BIT = 17;
    localparam int CSR_RX_UF_BIT = 18;
    localparam int CSR_RX_LSB    = 12;
    localparam int CSR_TX_LSB    = 8;

    // Four level flags of one FIFO, each 0 when its condition is true.
    typedef struct packed {
        logic full_n;
        logic afull_n;
        logic aempty_n;
        logic empty_n;
    } flags_n_t;
endpackage

// File: rtl/scb_byte_fifo.sv
// Module: circular FIFO with an occupancy counter.
// A push is accepted while the FIFO is not full, or while a pop happens in
// the same cycle; otherwise the push is dropped and reported on 'dropped'.
// A pop of an empty FIFO does nothing. head shows the oldest entry and is
// meaningful only when not empty.
// Assumes DEPTH >= 1. Reset is synchronous, active low.
module scb_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // Occupancy flags and accept decisions.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        dropped = push && !push_ok;
        head    = mem[rd_ptr];
    end

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R8
    drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> count == $past(count));

    // R10
    starve_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> count == 0);
endmodule

// File: rtl/scb_level_flags.sv
// Module: level flags and edge interrupts for one FIFO.
// Almost-full holds when count + afull_lvl >= DEPTH. The sum is one bit
// wider than the threshold, so a threshold above DEPTH does not wrap.
// Almost-empty holds when count <= aempty_lvl. The previous-state registers
// reset to 1, so reset release produces no pulse.
// Assumes DEPTH < 2**THR_W.
module scb_level_flags
    import scb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             full,
    input  logic             empty,
    input  logic [THR_W-1:0] afull_lvl,
    input  logic [THR_W-1:0] aempty_lvl,
    output flags_n_t         flags_n,
    output logic             irq_afull,
    output logic             irq_aempty
);
    logic [THR_W:0] af_sum;
    logic           afull_c;
    logic           aempty_c;
    logic           afull_q;
    logic           aempty_q;

    // Threshold comparisons and active-low flag bundle.
    always_comb begin
        af_sum           = {1'b0, afull_lvl} + (THR_W + 1)'(count);
        afull_c          = af_sum >= (THR_W + 1)'(DEPTH);
        aempty_c         = THR_W'(count) <= aempty_lvl;
        flags_n.full_n   = !full;
        flags_n.afull_n  = !afull_c;
        flags_n.aempty_n = !aempty_c;
        flags_n.empty_n  = !empty;
    end

    // Remember last cycle's conditions for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            afull_q  <= 1'b1;
            aempty_q <= 1'b1;
        end else begin
            afull_q  <= afull_c;
            aempty_q <= aempty_c;
        end
    end

    // Rising-edge pulses.
    assign irq_afull  = afull_c && !afull_q;
    assign irq_aempty = aempty_c && !aempty_q;

    // R11
    irq_af_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_afull |=> !irq_afull);

    // R11
    irq_ae_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_aempty |=> !irq_aempty);

    // R5
    full_implies_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !flags_n.afull_n);

    // R6
    empty_implies_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !flags_n.aempty_n);
endmodule

// File: rtl/scb_chan_regs.sv
// Module: register decode for one channel.
// Holds the two thresholds, the sticky overflow bits and the underflow bit.
// Turns data-register accesses into FIFO push and pop strobes, and registers
// the selected read word. reg_rdata changes only on a read and holds
// otherwise. In a cycle where a drop and a clearing write coincide, the set
// wins.
module scb_chan_regs
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic              rx_dropped,
    input  logic              tx_dropped,
    input  flags_n_t          rx_flags_n,
    input  flags_n_t          tx_flags_n,
    output logic [THR_W-1:0]  afull_lvl,
    output logic [THR_W-1:0]  aempty_lvl,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_push_data,
    output logic              rx_pop
);
    reg_sel_e          sel;
    logic              wr_levels;
    logic              wr_csr;
    logic              clr_rx_ov;
    logic              clr_tx_ov;
    logic              csr_rx_ov;
    logic              csr_tx_ov;
    logic              csr_rx_uf;
    logic [REG_W-1:0]  csr_word;
    logic [REG_W-1:0]  rd_word;

    // Access decode.
    always_comb begin
        sel          = reg_sel_e'(reg_sel);
        wr_levels    = reg_wr && (sel == SEL_LEVELS);
        wr_csr       = reg_wr && (sel == SEL_CSR);
        tx_push      = reg_wr && (sel == SEL_DATA);
        rx_pop       = reg_rd && (sel == SEL_DATA);
        tx_push_data = reg_wdata[BYTE_W-1:0];
        clr_rx_ov    = wr_csr && reg_wdata[CSR_RX_OV_BIT];
        clr_tx_ov    = wr_csr && reg_wdata[CSR_TX_OV_BIT];
    end

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            afull_lvl  <= '0;
            aempty_lvl <= '0;
        end else if (wr_levels) begin
            afull_lvl  <= reg_wdata[REG_W-1:THR_W];
            aempty_lvl <= reg_wdata[THR_W-1:0];
        end
    end

    // Sticky overflow bits and the underflow bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rx_ov <= 1'b0;
            csr_tx_ov <= 1'b0;
            csr_rx_uf <= 1'b0;
        end else begin
            csr_rx_ov <= rx_dropped || (csr_rx_ov && !clr_rx_ov);
            csr_tx_ov <= tx_dropped || (csr_tx_ov && !clr_tx_ov);
            if (rx_pop) csr_rx_uf <= rx_empty;
        end
    end

    // Status word assembly.
    always_comb begin
        csr_word                                 = '0;
        csr_word[CSR_RX_UF_BIT]                  = csr_rx_uf;
        csr_word[CSR_TX_OV_BIT]                  = csr_tx_ov;
        csr_word[CSR_RX_OV_BIT]                  = csr_rx_ov;
        csr_word[CSR_RX_LSB +: 4]                = rx_flags_n;
        csr_word[CSR_TX_LSB +: 4]                = tx_flags_n;
    end

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_LEVELS: rd_word = {afull_lvl, aempty_lvl};
            SEL_DATA:   rd_word = rx_empty ? '0 : REG_W'(rx_head);
            SEL_CSR:    rd_word = csr_word;
            default:    rd_word = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_word;
        end
    end

    // R8
    rx_drop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dropped |=> csr_rx_ov);

    // R8
    rx_ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rx_ov && !clr_rx_ov) |=> csr_rx_ov);

    // R9
    tx_drop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dropped |=> csr_tx_ov);

    // R9
    tx_ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_tx_ov && !clr_tx_ov) |=> csr_tx_ov);

    // R10
    uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> (csr_rx_uf && reg_rdata == '0));

    // R3
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> reg_rdata[REG_W-1:BYTE_W] == '0);
endmodule

// File: rtl/serial_chan_buf.sv
// Module: top of the serial channel buffer.
// Joins the register decode, the two byte FIFOs and the two level-flag
// units. The transmit FIFO is filled from the register side and drained by
// the line side; the receive FIFO works the other way round.
// Assumes 1 <= DEPTH < 65536.
module serial_chan_buf
    import scb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    output logic        irq_rx_afull,
    output logic        irq_rx_aempty,
    output logic        irq_tx_afull,
    output logic        irq_tx_aempty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [THR_W-1:0]  afull_lvl;
    logic [THR_W-1:0]  aempty_lvl;
    logic              tx_push;
    logic [BYTE_W-1:0] tx_push_data;
    logic              rx_pop;
    logic [BYTE_W-1:0] rx_head;
    logic [BYTE_W-1:0] tx_head;
    logic [CNT_W-1:0]  rx_count;
    logic [CNT_W-1:0]  tx_count;
    logic              rx_full;
    logic              rx_empty;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_dropped;
    logic              tx_dropped;
    flags_n_t          rx_flags_n;
    flags_n_t          tx_flags_n;

    scb_chan_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_head      (rx_head),
        .rx_empty     (rx_empty),
        .rx_dropped   (rx_dropped),
        .tx_dropped   (tx_dropped),
        .rx_flags_n   (rx_flags_n),
        .tx_flags_n   (tx_flags_n),
        .afull_lvl    (afull_lvl),
        .aempty_lvl   (aempty_lvl),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .rx_pop       (rx_pop)
    );

    scb_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .dropped   (tx_dropped)
    );

    scb_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .dropped   (rx_dropped)
    );

    scb_level_flags #(.DEPTH(DEPTH)) u_tx_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (tx_count),
        .full       (tx_full),
        .empty      (tx_empty),
        .afull_lvl  (afull_lvl),
        .aempty_lvl (aempty_lvl),
        .flags_n    (tx_flags_n),
        .irq_afull  (irq_tx_afull),
        .irq_aempty (irq_tx_aempty)
    );

    scb_level_flags #(.DEPTH(DEPTH)) u_rx_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (rx_count),
        .full       (rx_full),
        .empty      (rx_empty),
        .afull_lvl  (afull_lvl),
        .aempty_lvl (aempty_lvl),
        .flags_n    (rx_flags_n),
        .irq_afull  (irq_rx_afull),
        .irq_aempty (irq_rx_aempty)
    );

    // Line-side view of the transmit FIFO.
    assign tx_valid = !tx_empty;
    assign tx_data  = tx_head;

    // R2
    tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_pop && !tx_full) |=> tx_valid);
endmodule

// File: tb/serial_chan_buf_tb_top.sv
`timescale 1ns/1ps
// Bench: near-exhaustive threshold and fill-level sweeps at DEPTH 4, plus
// directed overflow, underflow, reset and pulse checks.
module serial_chan_buf_tb_top;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_pop = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        irq_rx_afull, irq_rx_aempty, irq_tx_afull, irq_tx_aempty;

    int n_checks = 0;
    int n_fail   = 0;

    serial_chan_buf #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data),
        .irq_rx_afull(irq_rx_afull), .irq_rx_aempty(irq_rx_aempty),
        .irq_tx_afull(irq_tx_afull), .irq_tx_aempty(irq_tx_aempty)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected active-low nibble {full, afull, aempty, empty}.
    function automatic logic [3:0] exp_nib(input int n, input int af, input int ae);
        return {n != D, (n + af) < D, n > ae, n != 0};
    endfunction

    function automatic logic [7:0] val(input int af, input int ae, input int n);
        return 8'(af * 37 + ae * 11 + n * 3 + 1);
    endfunction

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rx_put(input logic [7:0] b);
        rx_data = b; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: no pulse at reset release
        check({irq_rx_afull, irq_rx_aempty, irq_tx_afull, irq_tx_aempty} == 4'b0,
              "R11 irq at release", 32'({irq_rx_afull, irq_rx_aempty, irq_tx_afull, irq_tx_aempty}), 0);
        @(negedge clk);
        check({irq_rx_afull, irq_rx_aempty, irq_tx_afull, irq_tx_aempty} == 4'b0,
              "R11 irq after release", 32'({irq_rx_afull, irq_rx_aempty, irq_tx_afull, irq_tx_aempty}), 0);
        // R1: reset state
        check(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
        bus_read(2'd2, rd);
        check(rd == 32'h0000_CC00, "R1 status", rd, 32'h0000_CC00);
        bus_read(2'd0, rd);
        check(rd == 32'h0, "R1 levels", rd, 0);

        // R7: level register read-back
        bus_write(2'd0, 32'h0003_0002);
        bus_read(2'd0, rd);
        check(rd == 32'h0003_0002, "R7 levels", rd, 32'h0003_0002);

        // R2: upper write bits ignored
        bus_write(2'd1, 32'hABCD_EF5A);
        check(tx_valid && tx_data == 8'h5A, "R2 byte field", 32'({tx_valid, tx_data}), 32'h15A);
        tx_take();
        check(!tx_valid, "R2 tx drained", 32'(tx_valid), 0);

        // Receive sweep: R3 R4 R5 R6 R11
        for (int af = 0; af <= D + 1; af++) begin
            for (int ae = 0; ae <= D + 1; ae++) begin
                bus_write(2'd0, {16'(af), 16'(ae)});
                @(negedge clk);
                for (int n = 0; n <= D; n++) begin
                    bus_read(2'd2, rd);
                    check(rd[15:12] == exp_nib(n, af, ae), "R4 R5 R6 rx flags",
                          32'(rd[15:12]), 32'(exp_nib(n, af, ae)));
                    if (n < D) begin
                        rx_put(val(af, ae, n));
                        check(irq_rx_afull == ((n + 1 + af >= D) && (n + af < D)) && !irq_rx_aempty,
                              "R11 rx push irq", 32'({irq_rx_afull, irq_rx_aempty}),
                              32'({((n + 1 + af >= D) && (n + af < D)), 1'b0}));
                    end
                end
                for (int n = D; n > 0; n--) begin
                    bus_read(2'd1, rd);
                    check(rd == 32'(val(af, ae, D - n)), "R3 rx data order", rd, 32'(val(af, ae, D - n)));
                    check(irq_rx_aempty == ((n - 1 <= ae) && (n > ae)) && !irq_rx_afull,
                          "R11 rx pop irq", 32'({irq_rx_afull, irq_rx_aempty}),
                          32'({1'b0, ((n - 1 <= ae) && (n > ae))}));
                end
            end
        end

        // Transmit sweep: R2 R4 R5 R6 R11
        for (int af = 0; af <= D + 1; af++) begin
            for (int ae = 0; ae <= D + 1; ae++) begin
                bus_write(2'd0, {16'(af), 16'(ae)});
                @(negedge clk);
                for (int n = 0; n <= D; n++) begin
                    bus_read(2'd2, rd);
                    check(rd[11:8] == exp_nib(n, af, ae), "R4 R5 R6 tx flags",
                          32'(rd[11:8]), 32'(exp_nib(n, af, ae)));
                    if (n < D) begin
                        bus_write(2'd1, {24'hFFFFFF, val(af, ae, n)});
                        check(irq_tx_afull == ((n + 1 + af >= D) && (n + af < D)) && !irq_tx_aempty,
                              "R11 tx push irq", 32'({irq_tx_afull, irq_tx_aempty}),
                              32'({((n + 1 + af >= D) && (n + af < D)), 1'b0}));
                    end
                end
                for (int n = D; n > 0; n--) begin
                    check(tx_valid && tx_data == val(af, ae, D - n), "R2 tx data order",
                          32'({tx_valid, tx_data}), 32'({1'b1, val(af, ae, D - n)}));
                    tx_take();
                    check(irq_tx_aempty == ((n - 1 <= ae) && (n > ae)) && !irq_tx_afull,
                          "R11 tx pop irq", 32'({irq_tx_afull, irq_tx_aempty}),
                          32'({1'b0, ((n - 1 <= ae) && (n > ae))}));
                end
            end
        end

        // R8: receive overflow
        bus_write(2'd0, 32'h0);
        for (int i = 0; i < D; i++) rx_put(8'(8'h10 + i));
        rx_put(8'hEE);
        bus_read(2'd2, rd);
        check(rd[16] == 1'b1 && rd[15] == 1'b0, "R8 rx overflow set", rd, 32'h0001_0000);
        bus_write(2'd2, 32'h0);
        bus_read(2'd2, rd);
        check(rd[16] == 1'b1, "R8 write 0 keeps", 32'(rd[16]), 1);
        bus_write(2'd2, 32'h0001_0000);
        bus_read(2'd2, rd);
        check(rd[16] == 1'b0, "R8 write 1 clears", 32'(rd[16]), 0);
        // push coinciding with pop on a full FIFO
        rx_data = 8'h77; rx_push = 1'b1; reg_sel = 2'd1; reg_rd = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; reg_rd = 1'b0;
        check(reg_rdata == 32'h10, "R8 concurrent pop data", reg_rdata, 32'h10);
        bus_read(2'd2, rd);
        check(rd[16] == 1'b0 && rd[15] == 1'b0, "R8 concurrent accepted", rd, 32'h0);
        for (int i = 1; i <= D; i++) begin
            bus_read(2'd1, rd);
            check(rd == ((i < D) ? 32'(8'h10 + i) : 32'h77), "R8 rx contents", rd,
                  (i < D) ? 32'(8'h10 + i) : 32'h77);
        end

        // R9: transmit overflow
        for (int i = 0; i < D; i++) bus_write(2'd1, 32'(8'h20 + i));
        bus_write(2'd1, 32'hEE);
        bus_read(2'd2, rd);
        check(rd[17] == 1'b1 && rd[11] == 1'b0, "R9 tx overflow set", rd, 32'h0002_0000);
        bus_write(2'd2, 32'h0001_0000);
        bus_read(2'd2, rd);
        check(rd[17] == 1'b1, "R9 other bit keeps", 32'(rd[17]), 1);
        bus_write(2'd2, 32'h0002_0000);
        bus_read(2'd2, rd);
        check(rd[17] == 1'b0, "R9 write 1 clears", 32'(rd[17]), 0);
        for (int i = 0; i < D; i++) begin
            check(tx_data == 8'(8'h20 + i), "R9 tx contents", 32'(tx_data), 32'(8'h20 + i));
            tx_take();
        end
        check(!tx_valid, "R9 tx empty", 32'(tx_valid), 0);

        // R10: receive underflow
        bus_read(2'd1, rd);
        check(rd == 32'h0, "R10 empty read data", rd, 0);
        bus_read(2'd2, rd);
        check(rd[18] == 1'b1 && rd[12] == 1'b0, "R10 underflow set", rd, 32'h0004_0000);
        bus_read(2'd2, rd);
        check(rd[18] == 1'b1, "R10 underflow holds", 32'(rd[18]), 1);
        rx_put(8'h42);
        bus_read(2'd1, rd);
        check(rd == 32'h42, "R10 data after underflow", rd, 32'h42);
        bus_read(2'd2, rd);
        check(rd[18] == 1'b0, "R10 underflow cleared", 32'(rd[18]), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule